// File: doc/BRIEF.md
# Board Interrupt Expander Register Block

This block is a small register file that sits behind a chip select on a board-level logic device. Five peripheral interrupt requests are collected here: an Ethernet controller, two external UARTs and two push buttons. Each request line is synchronized, and its rising edge is latched into a sticky pending bit. A mask register decides which pending bits may reach the host. A write-only clear register removes pending bits. Whenever any unmasked pending bit is set, one active-low, level-sensitive interrupt line to the host is held low.

Software uses three fixed signature words at scattered offsets to check that the board is fitted. It then reads a code-version word and a board-ID word. The block also holds a general LED register and a module-reset register, each of which drives an output. A button readback register returns the level of a 16-bit input. All accesses use a plain synchronous bus with a 16-bit address, 16-bit write data, a write strobe, a read strobe and 16-bit registered read data.

Top module: `brdx_irq_expander`

## Requirements
- R1: Reads at byte offset 0x40 return 0xAAAA, reads at 0x48 return 0x5555 and reads at 0x58 return 0xCAFE. Writes to these offsets change nothing.
- R2: Read data is registered. The value for the address presented with `rd_en` appears on `rd_data` in the following cycle. The code-version word at 0x50 and the board-ID word at 0x68 return the parameters `CODE_VER` and `BOARD_ID`.
- R3: The pending register is read at 0x10, and writes to it are ignored. Bit 0 is the Ethernet source, bit 1 UART A, bit 2 UART B, bit 3 button A and bit 4 button B, taken from `src_req[4:0]` in the same order. A bit sets on a rising edge of its request, seen after a two-flop synchronizer. It stays set while the request remains high and after the request falls.
- R4: Writing the clear register at 0x20 clears every pending bit written as 1. Writing 0 to it clears nothing, and reads of it return 0x0000.
- R5: If a synchronized rising edge arrives in the same cycle as a clear of the same bit, the bit ends up set.
- R6: In the mask register at 0x38, a bit of 1 blocks that source and a bit of 0 lets it through. Only bits 4:0 are stored, and bits 15:5 read as 0.
- R7: `irq_n` is low exactly when (pending AND NOT mask) is non-zero, one clock after that value changes.
- R8: After reset, the mask is 0x001F, pending is 0, `irq_n` is 1, and `led_out` and `mod_rst_out` are 0.
- R9: The LED register at 0x00 and the module-reset register at 0x60 are read/write and drive `led_out` and `mod_rst_out`. A read at 0x08 returns `btn_in`.
- R10: Reads of any unmapped offset return 0x0000, and writes to unmapped offsets change no register.
- R11: The start-up sequence is: mask written 0, clear written 0xFFFF, clear written 0, mask written 0x1F. After it, pending is 0, the mask is 0x1F and `irq_n` is 1, whatever was pending before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Byte offset within the register window |
| wr_data | input | 16 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read data |
| src_req | input | 5 | Peripheral interrupt requests, asynchronous, active high |
| btn_in | input | 16 | Button levels for readback |
| led_out | output | 16 | LED register contents |
| mod_rst_out | output | 16 | Module-reset register contents |
| irq_n | output | 1 | Active-low level interrupt to the host |

## Verification
The assertions assume that `addr` and `wr_data` are stable for the cycle in which a strobe is high. They also assume that a request held high produces only one latch event. The bench meets both by changing every input on the falling clock edge. It holds `btn_in` steady around its reads. It lowers each request for at least three cycles before raising it again, so that every intended edge passes the synchronizer. The set-versus-clear race is produced by timing the clear write to land on the third rising edge after a request goes high.

// File: rtl/brdx_pkg.sv
package brdx_pkg;
  localparam int unsigned NSRC      = 5;
  localparam int unsigned DW        = 16;
  localparam int unsigned OFS_LED   = 'h00;
  localparam int unsigned OFS_BTN   = 'h08;
  localparam int unsigned OFS_PEND  = 'h10;
  localparam int unsigned OFS_CLR   = 'h20;
  localparam int unsigned OFS_MASK  = 'h38;
  localparam int unsigned OFS_SIG0  = 'h40;
  localparam int unsigned OFS_SIG1  = 'h48;
  localparam int unsigned OFS_VER   = 'h50;
  localparam int unsigned OFS_SIG2  = 'h58;
  localparam int unsigned OFS_MRST  = 'h60;
  localparam int unsigned OFS_ID    = 'h68;
  localparam logic [DW-1:0] SIG0_VAL = 16'hAAAA;
  localparam logic [DW-1:0] SIG1_VAL = 16'h5555;
  localparam logic [DW-1:0] SIG2_VAL = 16'hCAFE;

  // next pending state: a fresh edge outranks a clear
  function automatic logic [DW-1:0] next_pend(input logic [DW-1:0] cur,
                                              input logic [DW-1:0] clr,
                                              input logic [DW-1:0] rise);
    return (cur & ~clr) | rise;
  endfunction

  function automatic logic [DW-1:0] live_of(input logic [DW-1:0] pend,
                                            input logic [DW-1:0] mask);
    return pend & ~mask;
  endfunction
endpackage

// File: rtl/brdx_edge_latch.sv
module brdx_edge_latch #(
  parameter int N    = 5,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] rise
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [SYNC:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[SYNC-1:0], req[g]};
    end
    assign rise[g] = sh[SYNC-1] & ~sh[SYNC];
  end
endmodule

// File: rtl/brdx_irq_core.sv
module brdx_irq_core
  import brdx_pkg::*;
#(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rise,
  input  logic [N-1:0] clr,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wd,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] live,
  output logic         irq_n
);
  logic [DW-1:0] pend_nx16;
  logic [DW-1:0] live16;

  assign pend_nx16 = next_pend(DW'(pend_q), DW'(clr), DW'(rise));
  assign live16    = live_of(DW'(pend_q), DW'(mask_q));
  assign live      = live16[N-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '1;
      irq_n  <= 1'b1;
    end else begin
      pend_q <= pend_nx16[N-1:0];
      if (mask_we) mask_q <= mask_wd;
      irq_n  <= ~|live;
    end
  end
endmodule

// File: rtl/brdx_irq_expander.sv
module brdx_irq_expander
  import brdx_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] CODE_VER = 16'h0102,
  parameter logic [15:0] BOARD_ID = 16'h0051
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wr_data,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [15:0]       rd_data,
  input  logic [4:0]        src_req,
  input  logic [15:0]       btn_in,
  output logic [15:0]       led_out,
  output logic [15:0]       mod_rst_out,
  output logic              irq_n
);
  localparam int N = NSRC;

  // named internal events for the checker
  logic [N-1:0] rise_vec;
  logic [N-1:0] clr_vec;
  logic [N-1:0] pend_q;
  logic [N-1:0] mask_q;
  logic [N-1:0] live_vec;
  logic         mask_we;
  logic [15:0]  rd_mux;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign mask_we = wr_en && hit(addr, OFS_MASK);
  assign clr_vec = (wr_en && hit(addr, OFS_CLR)) ? wr_data[N-1:0] : '0;

  brdx_edge_latch #(.N(N), .SYNC(2)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (src_req),
    .rise (rise_vec)
  );

  brdx_irq_core #(.N(N)) u_core (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise   (rise_vec),
    .clr    (clr_vec),
    .mask_we(mask_we),
    .mask_wd(wr_data[N-1:0]),
    .pend_q (pend_q),
    .mask_q (mask_q),
    .live   (live_vec),
    .irq_n  (irq_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      led_out     <= '0;
      mod_rst_out <= '0;
    end else if (wr_en) begin
      if (hit(addr, OFS_LED))  led_out     <= wr_data;
      if (hit(addr, OFS_MRST)) mod_rst_out <= wr_data;
    end
  end

  always_comb begin
    rd_mux = '0;
    if      (hit(addr, OFS_LED))  rd_mux = led_out;
    else if (hit(addr, OFS_BTN))  rd_mux = btn_in;
    else if (hit(addr, OFS_PEND)) rd_mux = 16'(pend_q);
    else if (hit(addr, OFS_MASK)) rd_mux = 16'(mask_q);
    else if (hit(addr, OFS_SIG0)) rd_mux = SIG0_VAL;
    else if (hit(addr, OFS_SIG1)) rd_mux = SIG1_VAL;
    else if (hit(addr, OFS_VER))  rd_mux = CODE_VER;
    else if (hit(addr, OFS_SIG2)) rd_mux = SIG2_VAL;
    else if (hit(addr, OFS_MRST)) rd_mux = mod_rst_out;
    else if (hit(addr, OFS_ID))   rd_mux = BOARD_ID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/brdx_irq_expander_chk.sv
module brdx_irq_expander_chk #(
  parameter int ADDR_W = 16,
  parameter int N      = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic [15:0]       rd_data,
  input logic [N-1:0]      rise_vec,
  input logic [N-1:0]      clr_vec,
  input logic [N-1:0]      pend_q,
  input logic [N-1:0]      mask_q,
  input logic              irq_n
);
  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_vec != '0) |=> ((pend_q & $past(rise_vec)) == $past(rise_vec)));

  // R4
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~rise_vec) != '0) |=> ((pend_q & $past(clr_vec & ~rise_vec)) == '0));

  // R3
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(rise_vec)) == '0));

  // R7
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_n == ~|$past(pend_q & ~mask_q)));

  // R1
  sig0_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'('h40)) |=> (rd_data == 16'hAAAA));

  // R4
  clr_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'('h20)) |=> (rd_data == 16'h0000));
endmodule

bind brdx_irq_expander brdx_irq_expander_chk #(.ADDR_W(ADDR_W), .N(N)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (addr),
  .rd_en   (rd_en),
  .rd_data (rd_data),
  .rise_vec(rise_vec),
  .clr_vec (clr_vec),
  .pend_q  (pend_q),
  .mask_q  (mask_q),
  .irq_n   (irq_n)
);

// File: tb/brdx_irq_expander_tb.sv
module brdx_irq_expander_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [15:0] wr_data = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic [4:0]  src_req = '0;
  logic [15:0] btn_in = '0;
  logic [15:0] led_out;
  logic [15:0] mod_rst_out;
  logic        irq_n;

  int n_cmp = 0;
  int n_bad = 0;
  logic [4:0] e_mask;

  always #4 clk = ~clk;

  brdx_irq_expander #(.ADDR_W(16), .CODE_VER(16'h0102), .BOARD_ID(16'h0051)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
    .rd_en(rd_en), .rd_data(rd_data), .src_req(src_req), .btn_in(btn_in),
    .led_out(led_out), .mod_rst_out(mod_rst_out), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
    end
  endtask

  // all tasks start and end on a falling edge
  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic exp_irq_n(input logic [4:0] p, input logic [4:0] m);
    return ((p & ~m) == 5'd0);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R8 reset state
    chk("R8 irq_n", 16'(irq_n), 16'h1);
    chk("R8 led_out", led_out, 16'h0);
    chk("R8 mod_rst_out", mod_rst_out, 16'h0);
    rd_chk("R8 mask", 16'h38, 16'h001F);
    rd_chk("R8 pend", 16'h10, 16'h0000);
    // R1 signatures, also immune to writes
    rd_chk("R1 sig0", 16'h40, 16'hAAAA);
    rd_chk("R1 sig1", 16'h48, 16'h5555);
    rd_chk("R1 sig2", 16'h58, 16'hCAFE);
    wr(16'h48, 16'h0000);
    rd_chk("R1 sig1 after write", 16'h48, 16'h5555);
    // R2 version and ID, registered read holds between reads
    rd_chk("R2 ver", 16'h50, 16'h0102);
    rd_chk("R2 id", 16'h68, 16'h0051);
    addr = 16'h40; idle(2);
    chk("R2 rd_data held", rd_data, 16'h0051);
    // R9 LED, module reset, buttons
    wr(16'h00, 16'h1234);
    chk("R9 led_out", led_out, 16'h1234);
    rd_chk("R9 led read", 16'h00, 16'h1234);
    wr(16'h60, 16'h00A5);
    chk("R9 mod_rst_out", mod_rst_out, 16'h00A5);
    rd_chk("R9 mrst read", 16'h60, 16'h00A5);
    btn_in = 16'hBEEF;
    rd_chk("R9 buttons", 16'h08, 16'hBEEF);
    // R10 unmapped offsets
    foreach (v[i]) begin end
    rd_chk("R10 unmapped 0x18", 16'h18, 16'h0000);
    rd_chk("R10 unmapped 0x30", 16'h30, 16'h0000);
    rd_chk("R10 unmapped 0x70", 16'h70, 16'h0000);
    rd_chk("R10 unmapped 0x1038", 16'h1038, 16'h0000);
    wr(16'h18, 16'hFFFF);
    wr(16'h1000, 16'hFFFF);
    wr(16'h1038, 16'h0000);
    chk("R10 led kept", led_out, 16'h1234);
    chk("R10 mrst kept", mod_rst_out, 16'h00A5);
    rd_chk("R10 mask kept", 16'h38, 16'h001F);

    // R11 start-up with something already pending
    src_req[1] = 1'b1; idle(5); src_req[1] = 1'b0; idle(3);
    chk("R11 pre irq_n masked", 16'(irq_n), 16'h1);
    wr(16'h38, 16'h0000); idle(2);
    chk("R11 irq_n after mask 0", 16'(irq_n), 16'h0);
    wr(16'h20, 16'hFFFF); idle(2);
    chk("R11 irq_n after clear all", 16'(irq_n), 16'h1);
    wr(16'h20, 16'h0000); idle(2);
    chk("R11 irq_n after clear 0", 16'(irq_n), 16'h1);
    wr(16'h38, 16'h001F); idle(2);
    chk("R11 irq_n after mask 1F", 16'(irq_n), 16'h1);
    rd_chk("R11 pend", 16'h10, 16'h0000);
    rd_chk("R11 mask", 16'h38, 16'h001F);

    // R3 R4 R6 R7 per source latch/unmask/ack
    e_mask = 5'h1F;
    for (int i = 0; i < 5; i++) begin
      src_req[i] = 1'b1; idle(5);
      rd_chk($sformatf("R3 latch src%0d", i), 16'h10, 16'(5'd1 << i));
      chk($sformatf("R6 masked src%0d irq_n", i), 16'(irq_n), 16'h1);
      rd(16'h38, v);
      wr(16'h38, v & ~(16'h1 << i)); idle(2);
      chk($sformatf("R7 unmasked src%0d irq_n", i), 16'(irq_n), 16'h0);
      wr(16'h20, 16'h0000); idle(2);
      rd_chk($sformatf("R4 zero write src%0d", i), 16'h10, 16'(5'd1 << i));
      rd_chk($sformatf("R4 clr reads 0 src%0d", i), 16'h20, 16'h0000);
      wr(16'h20, 16'h1 << i);
      wr(16'h20, 16'h0000); idle(2);
      rd_chk($sformatf("R3 held level no relatch src%0d", i), 16'h10, 16'h0000);
      chk($sformatf("R7 acked src%0d irq_n", i), 16'(irq_n), 16'h1);
      rd(16'h38, v);
      wr(16'h38, v | (16'h1 << i)); idle(1);
      src_req[i] = 1'b0; idle(4);
      rd_chk($sformatf("R3 fall no set src%0d", i), 16'h10, 16'h0000);
    end

    // R6 R7 mask sweep with all five pending
    src_req = 5'h1F; idle(5); src_req = 5'h00; idle(4);
    rd_chk("R3 all pending", 16'h10, 16'h001F);
    for (int m = 0; m < 32; m++) begin
      wr(16'hFFE0 | 16'(m), 16'hFFE0 | 16'(m));
      wr(16'h38, 16'hFFE0 | 16'(m)); idle(2);
      chk($sformatf("R7 irq_n mask %0d", m), 16'(irq_n), 16'(exp_irq_n(5'h1F, 5'(m))));
      rd_chk($sformatf("R6 mask readback %0d", m), 16'h38, 16'(m));
    end
    // R4 clearing one bit at a time, irq with mask 0
    wr(16'h38, 16'h0000);
    for (int j = 0; j < 5; j++) begin
      wr(16'h20, 16'h1 << j);
      wr(16'h20, 16'h0000); idle(2);
      rd_chk($sformatf("R4 partial clear %0d", j), 16'h10, 16'(5'h1F & ~((5'd2 << j) - 5'd1)));
      chk($sformatf("R7 partial irq_n %0d", j), 16'(irq_n), 16'(exp_irq_n(5'h1F & ~((5'd2 << j) - 5'd1), 5'h00)));
    end
    // R3 status register is read-only
    wr(16'h10, 16'h001F); idle(1);
    rd_chk("R3 pend write ignored", 16'h10, 16'h0000);

    // R5 edge and clear in the same cycle
    idle(3);
    src_req[0] = 1'b1;
    idle(2);
    wr(16'h20, 16'h0001);
    wr(16'h20, 16'h0000);
    rd_chk("R5 set wins", 16'h10, 16'h0001);
    idle(2);
    chk("R5 irq_n low", 16'(irq_n), 16'h0);
    src_req[0] = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule